// File: doc/BRIEF.md
# Endian-Aware Byte-Lane Bus Sequencer

This block sits between a local requester and an external data bus that may be narrower than, or as wide as, a 32-bit local word. The requester gives a byte address, an access size of one, two or four bytes, write data, a read/write flag and a byte-order flag. The block then runs one or more external cycles. Each cycle carries a lane-aligned address, per-lane byte selects and a read or write strobe. A 32-bit access on a 16-bit bus becomes two cycles. A byte access on a 16-bit bus becomes a single cycle with one byte select active.

The byte-order flag decides which byte of the local value travels at the lowest external address. With little-endian order the least significant byte comes first. With big-endian order the most significant byte comes first. For reads, bytes from all cycles are gathered into a right-justified, zero-extended result, and a one-cycle completion pulse marks it valid. Accesses that are not aligned to their own size, and the reserved size code, are refused: the block pulses an error and runs no external cycle.

External lane j carries the byte whose address has j as its low bits, modulo the bus width in bytes (parameter `EXT_BYTES`: 1, 2 or 4).

Top module: `bls_seq`

## Requirements
- R1: After reset, and until the first request, `busy`, `done`, `err`, `ext_rd`, `ext_wr` and every bit of `ext_bsel` are low.
- R2: A request sampled while idle whose size code is 3, or whose address is not a multiple of its size (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), raises `err` for exactly the next cycle. It causes no strobe, no `done` and no change to external memory.
- R3: During each external cycle, `ext_bsel` has bit j set exactly for the lanes the access covers: all `EXT_BYTES` lanes when the size is at least the bus width, otherwise `size` lanes starting at lane `addr mod EXT_BYTES`. Outside external cycles, `ext_bsel` is zero.
- R4: An accepted access runs max(1, size/EXT_BYTES) external cycles of one clock each, back to back, starting in the cycle after acceptance. Each cycle's address is `EXT_BYTES` higher than the previous one.
- R5: With `big_endian` low, the byte at access offset k (address addr+k) is bits [8k+7:8k] of the local value.
- R6: With `big_endian` high, the byte at access offset k is bits [8(n-1-k)+7:8(n-1-k)] of the local value, where n is the access size in bytes.
- R7: For reads, `rdata` holds the gathered bytes in the order given by R5/R6, with zero in the bytes above the access size. `done` is high for exactly one cycle, the cycle right after the last external cycle, and `rdata` is valid in that cycle.
- R8: `ext_rd` is high only for read accesses and `ext_wr` only for write accesses; the two are never high together.
- R9: A request raised while `busy` is high is ignored. It adds no external cycle and writes no memory.
- R10: `ext_addr` always has its low log2(EXT_BYTES) bits at zero while a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled while idle |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| wdata | input | 32 | Right-justified write value |
| write | input | 1 | 1 = write, 0 = read |
| big_endian | input | 1 | 1 = most significant byte at lowest address |
| busy | output | 1 | External cycles in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| rdata | output | 32 | Gathered read value, valid with `done` |
| ext_addr | output | ADDR_W | Lane-aligned external address |
| ext_wdata | output | 8*EXT_BYTES | External write data, zero on unselected lanes |
| ext_rdata | input | 8*EXT_BYTES | External read data, sampled at the end of each read cycle |
| ext_bsel | output | EXT_BYTES | Per-lane byte selects, active high |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |

## Verification
A request sampled at one rising edge produces either `err` or the first external cycle in the following cycle. Every further cycle follows on the next clock, and `done` arrives in the cycle after the last strobe. The bench raises `req` for one clock at a falling edge and samples outputs at each later falling edge. It counts the cycles it has seen, and each address and byte select is compared against the value for that cycle's beat index. `done` must appear exactly when that count equals the expected number of beats. Memory behind the external bus is a byte model in the bench, updated on write strobes and read combinationally. Endian placement is therefore judged on the stored bytes and on the gathered result, not on internal signals.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } seq_state_e;

    localparam int LOCAL_BYTES = 4;
    localparam int LOCAL_W     = LOCAL_BYTES * 8;

    // Per-access beat description, latched when an access is accepted.
    typedef struct packed {
        logic [2:0] nbytes;    // access size in bytes
        logic [2:0] per_beat;  // bytes moved per external cycle
        logic [2:0] nbeats;    // number of external cycles
        logic [1:0] lane_off;  // first active lane
    } beat_plan_t;

    function automatic logic [2:0] size_to_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic is_misaligned(logic [1:0] low, logic [2:0] nb);
        logic [1:0] mask;
        mask = 2'(nb - 3'd1);
        return (low & mask) != 2'd0;
    endfunction

endpackage

// File: rtl/bls_plan.sv
module bls_plan
    import bls_pkg::*;
#(
    parameter int EXT_BYTES = 2
) (
    input  logic [1:0] addr_lo,
    input  acc_size_e  size,
    output beat_plan_t plan,
    output logic       bad
);
    localparam int         LG       = $clog2(EXT_BYTES);
    localparam logic [1:0] OFF_MASK = 2'(EXT_BYTES - 1);
    localparam logic [2:0] EXT_NB   = 3'(EXT_BYTES);

    logic [2:0] nb;

    always_comb begin
        nb          = size_to_bytes(size);
        plan.nbytes = nb;
        bad         = (size == SZ_RSVD) || is_misaligned(addr_lo, nb);
        if (nb < EXT_NB) begin
            plan.per_beat = nb;
            plan.nbeats   = 3'd1;
            plan.lane_off = addr_lo & OFF_MASK;
        end else begin
            plan.per_beat = EXT_NB;
            plan.nbeats   = nb >> LG;
            plan.lane_off = 2'd0;
        end
    end

endmodule

// File: rtl/bls_lane_map.sv
module bls_lane_map
    import bls_pkg::*;
#(
    parameter int EXT_BYTES = 2
) (
    input  logic [2:0]                  nbytes,
    input  logic [2:0]                  per_beat,
    input  logic [1:0]                  lane_off,
    input  logic [2:0]                  beat,
    input  logic                        big_endian,
    input  logic [LOCAL_W-1:0]          wdata,
    output logic [EXT_BYTES-1:0]        lane_en,
    output logic [EXT_BYTES-1:0][1:0]   lane_idx,
    output logic [EXT_BYTES*8-1:0]      lane_wdata
);
    for (genvar j = 0; j < EXT_BYTES; j++) begin : g_lane
        logic       en_j;
        logic [1:0] ofs_j;   // offset of this lane's byte within the access
        logic [1:0] idx_j;   // byte index inside the local value

        always_comb begin
            ofs_j = 2'((int'(beat) * EXT_BYTES) + j - int'(lane_off));
            en_j  = (j >= int'(lane_off)) &&
                    (j < int'(lane_off) + int'(per_beat));
            idx_j = big_endian ? (2'(nbytes - 3'd1) - ofs_j) : ofs_j;
        end

        assign lane_en[j]          = en_j;
        assign lane_idx[j]         = idx_j;
        assign lane_wdata[j*8 +: 8] = en_j ? wdata[{idx_j, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/bls_gather.sv
module bls_gather
    import bls_pkg::*;
#(
    parameter int EXT_BYTES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [EXT_BYTES-1:0]      lane_en,
    input  logic [EXT_BYTES-1:0][1:0] lane_idx,
    input  logic [EXT_BYTES*8-1:0]    ext_rdata,
    output logic [LOCAL_W-1:0]        result
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            result <= '0;
        end else if (capture) begin
            for (int j = 0; j < EXT_BYTES; j++) begin
                if (lane_en[j]) begin
                    result[{lane_idx[j], 3'b000} +: 8] <= ext_rdata[j*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/bls_seq.sv
module bls_seq
    import bls_pkg::*;
#(
    parameter int EXT_BYTES = 2,
    parameter int ADDR_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             size,
    input  logic [31:0]            wdata,
    input  logic                   write,
    input  logic                   big_endian,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [31:0]            rdata,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic [EXT_BYTES*8-1:0] ext_wdata,
    input  logic [EXT_BYTES*8-1:0] ext_rdata,
    output logic [EXT_BYTES-1:0]   ext_bsel,
    output logic                   ext_rd,
    output logic                   ext_wr
);
    localparam int              LG        = $clog2(EXT_BYTES);
    localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(EXT_BYTES - 1);

    seq_state_e         state;
    beat_plan_t         plan_in, plan_q;
    logic               bad_in;
    logic [2:0]         beat;
    logic [ADDR_W-1:0]  base_q;
    logic [LOCAL_W-1:0] wdata_q;
    logic               write_q;
    logic               be_q;
    logic               accept;
    logic               last_beat;

    logic [EXT_BYTES-1:0]      lane_en;
    logic [EXT_BYTES-1:0][1:0] lane_idx;
    logic [EXT_BYTES*8-1:0]    lane_wdata;

    bls_plan #(.EXT_BYTES(EXT_BYTES)) plan_i (
        .addr_lo (addr[1:0]),
        .size    (acc_size_e'(size)),
        .plan    (plan_in),
        .bad     (bad_in)
    );

    bls_lane_map #(.EXT_BYTES(EXT_BYTES)) map_i (
        .nbytes     (plan_q.nbytes),
        .per_beat   (plan_q.per_beat),
        .lane_off   (plan_q.lane_off),
        .beat       (beat),
        .big_endian (be_q),
        .wdata      (wdata_q),
        .lane_en    (lane_en),
        .lane_idx   (lane_idx),
        .lane_wdata (lane_wdata)
    );

    assign accept    = (state == ST_IDLE) && req && !bad_in;
    assign last_beat = (beat == plan_q.nbeats - 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            beat    <= 3'd0;
            done    <= 1'b0;
            err     <= 1'b0;
            plan_q  <= '0;
            base_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            be_q    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req && bad_in) begin
                        err <= 1'b1;
                    end else if (accept) begin
                        state   <= ST_BEAT;
                        beat    <= 3'd0;
                        plan_q  <= plan_in;
                        base_q  <= addr & ~LANE_MASK;
                        wdata_q <= wdata;
                        write_q <= write;
                        be_q    <= big_endian;
                    end
                end
                ST_BEAT: begin
                    if (last_beat) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        beat <= beat + 3'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state == ST_BEAT);
    assign ext_rd    = busy && !write_q;
    assign ext_wr    = busy && write_q;
    assign ext_bsel  = busy ? lane_en : '0;
    assign ext_wdata = ext_wr ? lane_wdata : '0;
    assign ext_addr  = busy ? (base_q + (ADDR_W'(beat) << LG)) : '0;

    bls_gather #(.EXT_BYTES(EXT_BYTES)) gather_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .capture   (ext_rd),
        .lane_en   (lane_en),
        .lane_idx  (lane_idx),
        .ext_rdata (ext_rdata),
        .result    (rdata)
    );

endmodule

// File: rtl/bls_seq_chk.sv
module bls_seq_chk #(
    parameter int EXT_BYTES = 2,
    parameter int ADDR_W    = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic                 busy,
    input logic                 done,
    input logic                 err,
    input logic [ADDR_W-1:0]    ext_addr,
    input logic [EXT_BYTES-1:0] ext_bsel,
    input logic                 ext_rd,
    input logic                 ext_wr
);
    localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(EXT_BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(EXT_BYTES);

    logic strobe;
    assign strobe = ext_rd || ext_wr;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !err && !strobe && ext_bsel == '0));

    a_r2_err_follows_idle_req: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(req) && !$past(busy)));

    a_r2_err_without_cycle: assert property (@(posedge clk) disable iff (rst)
        err |-> (!strobe && !busy && !done));

    a_r3_bsel_only_in_cycle: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> (ext_bsel == '0));

    a_r3_bsel_nonempty: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (ext_bsel != '0));

    a_r4_ascending_beats: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> (ext_addr == $past(ext_addr) + STEP));

    a_r7_done_after_cycle: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(strobe) && !busy));

    a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_rd, ext_wr}));

    a_r10_lane_aligned_addr: assert property (@(posedge clk) disable iff (rst)
        strobe |-> ((ext_addr & LANE_MASK) == '0));

endmodule

bind bls_seq bls_seq_chk #(
    .EXT_BYTES (EXT_BYTES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .ext_addr (ext_addr),
    .ext_bsel (ext_bsel),
    .ext_rd   (ext_rd),
    .ext_wr   (ext_wr)
);

// File: tb/bls_seq_tb_top.sv
`timescale 1ns/1ps
module bls_seq_tb_top;
    localparam int EB = 2;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, req, write, big_endian;
    logic [AW-1:0] addr;
    logic [1:0]    size;
    logic [31:0]   wdata;
    logic          busy, done, err;
    logic [31:0]   rdata;
    logic [AW-1:0] ext_addr;
    logic [EB*8-1:0] ext_wdata, ext_rdata;
    logic [EB-1:0] ext_bsel;
    logic          ext_rd, ext_wr;

    bls_seq #(.EXT_BYTES(EB), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .size(size),
        .wdata(wdata), .write(write), .big_endian(big_endian),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_bsel(ext_bsel), .ext_rd(ext_rd), .ext_wr(ext_wr)
    );

    logic [7:0] mem [0:63];

    always_comb begin
        for (int j = 0; j < EB; j++)
            ext_rdata[j*8 +: 8] = mem[(int'(ext_addr[5:0]) + j) & 63];
    end

    int n_run  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    endtask

    function automatic int size_bytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] val_byte(input logic [31:0] v, input int nb,
                                            input int k, input bit be);
        return be ? v[(nb-1-k)*8 +: 8] : v[k*8 +: 8];
    endfunction

    // Issues one request and follows it to completion, checking each external cycle.
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit w,
                          input bit be, input logic [31:0] v, output int beats,
                          output bit got_err, output bit got_done,
                          output logic [31:0] rd);
        int nb;
        logic [EB-1:0] exp_sel;
        logic [31:0]   exp_addr;
        nb = size_bytes(sz);
        beats = 0; got_err = 0; got_done = 0; rd = '0;
        @(negedge clk);
        addr = a; size = sz; write = w; big_endian = be; wdata = v; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int t = 0; t < 12; t++) begin
            if (err) begin got_err = 1; break; end
            if (done) begin
                got_done = 1;
                rd = rdata;
                check(t == beats, "R7", "done cycle index", t, beats);
                break;
            end
            if (ext_rd || ext_wr) begin
                exp_addr = (a & ~32'(EB - 1)) + 32'(beats * EB);
                check(ext_addr == exp_addr, "R4 R10", "beat address", ext_addr, exp_addr);
                if (nb >= EB) exp_sel = '1;
                else exp_sel = EB'(((1 << nb) - 1) << (int'(a) % EB));
                check(ext_bsel == exp_sel, "R3", "byte selects", 32'(ext_bsel), 32'(exp_sel));
                check((ext_wr == w) && (ext_rd == !w), "R8", "strobe kind",
                      {30'd0, ext_rd, ext_wr}, {30'd0, !w, w});
                if (ext_wr)
                    for (int j = 0; j < EB; j++)
                        if (ext_bsel[j]) mem[(int'(ext_addr[5:0]) + j) & 63] = ext_wdata[j*8 +: 8];
                beats++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; req = 1'b0; addr = '0; size = '0; write = 1'b0;
        big_endian = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !ext_rd && !ext_wr && ext_bsel == '0, "R1",
              "idle outputs", {27'd0, busy, done, err, ext_rd, ext_wr}, 32'd0);
    endtask

    task automatic t_word_write(input bit be);
        int beats; bit e, d; logic [31:0] rd;
        logic [7:0] before_lo, before_hi;
        fill_mem();
        before_lo = mem[8'h0F]; before_hi = mem[8'h14];
        access(32'h10, 2'd2, 1'b1, be, 32'hCC428B5E, beats, e, d, rd);
        check(beats == 2 && d && !e, "R4", "word write beats", beats, 2);
        for (int k = 0; k < 4; k++)
            check(mem[8'h10 + k] == val_byte(32'hCC428B5E, 4, k, be), be ? "R6" : "R5",
                  "word write byte", mem[8'h10 + k], val_byte(32'hCC428B5E, 4, k, be));
        check(mem[8'h0F] == before_lo && mem[8'h14] == before_hi, "R3",
              "neighbours untouched", {mem[8'h0F], mem[8'h14]}, {before_lo, before_hi});
    endtask

    task automatic t_word_read(input bit be);
        int beats; bit e, d; logic [31:0] rd, exp;
        fill_mem();
        exp = be ? {mem[8'h18], mem[8'h19], mem[8'h1A], mem[8'h1B]}
                 : {mem[8'h1B], mem[8'h1A], mem[8'h19], mem[8'h18]};
        access(32'h18, 2'd2, 1'b0, be, 32'h0, beats, e, d, rd);
        check(beats == 2 && d, "R4", "word read beats", beats, 2);
        check(rd == exp, be ? "R6 R7" : "R5 R7", "word read value", rd, exp);
    endtask

    task automatic t_half_write(input bit be);
        int beats; bit e, d; logic [31:0] rd;
        fill_mem();
        access(32'h22, 2'd1, 1'b1, be, 32'h00008B5E, beats, e, d, rd);
        check(beats == 1 && d, "R4", "half write beats", beats, 1);
        check(mem[8'h22] == (be ? 8'h8B : 8'h5E), be ? "R6" : "R5", "half low address",
              mem[8'h22], be ? 8'h8B : 8'h5E);
        check(mem[8'h23] == (be ? 8'h5E : 8'h8B), be ? "R6" : "R5", "half high address",
              mem[8'h23], be ? 8'h5E : 8'h8B);
    endtask

    task automatic t_byte_write_odd();
        int beats; bit e, d; logic [31:0] rd;
        logic [7:0] keep;
        fill_mem();
        keep = mem[8'h24];
        access(32'h25, 2'd0, 1'b1, 1'b1, 32'h123456A7, beats, e, d, rd);
        check(mem[8'h25] == 8'hA7, "R6", "byte write odd lane", mem[8'h25], 8'hA7);
        check(mem[8'h24] == keep, "R3", "other lane kept", mem[8'h24], keep);
    endtask

    task automatic t_narrow_reads();
        int beats; bit e, d; logic [31:0] rd, exp;
        fill_mem();
        exp = {16'd0, mem[8'h06], mem[8'h07]};
        access(32'h06, 2'd1, 1'b0, 1'b1, 32'h0, beats, e, d, rd);
        check(rd == exp, "R7", "half read big-endian zero-extended", rd, exp);
        exp = {24'd0, mem[8'h09]};
        access(32'h09, 2'd0, 1'b0, 1'b0, 32'h0, beats, e, d, rd);
        check(rd == exp, "R7", "byte read odd address", rd, exp);
    endtask

    task automatic t_errors();
        int beats; bit e, d; logic [31:0] rd;
        logic [31:0] bad_a [4] = '{32'h03, 32'h02, 32'h01, 32'h00};
        logic [1:0]  bad_s [4] = '{2'd1, 2'd2, 2'd2, 2'd3};
        fill_mem();
        for (int i = 0; i < 4; i++) begin
            access(bad_a[i], bad_s[i], 1'b1, 1'b0, 32'hFFFFFFFF, beats, e, d, rd);
            check(e && !d && beats == 0, "R2", "refused access", {30'd0, e, d}, 32'd2);
        end
        check(mem[0] == 8'd3 && mem[1] == 8'd10 && mem[2] == 8'd17 && mem[3] == 8'd24,
              "R2", "memory unchanged", {mem[0], mem[1], mem[2], mem[3]}, {8'd3, 8'd10, 8'd17, 8'd24});
    endtask

    task automatic t_busy_ignore();
        int strobes;
        logic [7:0] keep;
        fill_mem();
        keep = mem[8'h38];
        strobes = 0;
        @(negedge clk);
        addr = 32'h30; size = 2'd2; write = 1'b1; big_endian = 1'b0;
        wdata = 32'h44332211; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int t = 0; t < 10; t++) begin
            if (ext_wr) begin
                strobes++;
                for (int j = 0; j < EB; j++)
                    if (ext_bsel[j]) mem[(int'(ext_addr[5:0]) + j) & 63] = ext_wdata[j*8 +: 8];
            end
            if (t == 0) begin
                addr = 32'h38; size = 2'd0; wdata = 32'h000000EE; req = 1'b1;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        check(strobes == 2, "R9", "cycles with overlapping request", strobes, 2);
        check(mem[8'h38] == keep, "R9", "ignored request wrote nothing", mem[8'h38], keep);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        fill_mem();
        t_reset();
        t_word_write(1'b0);
        t_word_write(1'b1);
        t_word_read(1'b0);
        t_word_read(1'b1);
        t_half_write(1'b0);
        t_half_write(1'b1);
        t_byte_write_odd();
        t_narrow_reads();
        t_errors();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule